// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Aggregator

This block gathers the event strobes of a network MAC into one sticky interrupt status word and drives a single interrupt line. The sources are runt frames that also carry a CRC error, completion of a management transaction, a change of PHY status, the general timer reaching zero, a bus master abort, transmit and receive status being posted, and a catch-all for other pending status. Software reads and clears the word through a small register port. It also sets a per-bit enable mask there.

Runt frames that fail CRC are counted in a saturating counter. When the counter's top bit first becomes set, an overflow status bit is raised. A bus master abort records the identity of the DMA queue that was active and freezes DMA on all queues. The freeze lasts until software has cleared the abort status and then pulses the restart input. The receive status bit is qualified by three receive enables and cannot assert unless all of them are set.

Top module: `mac_irq_agg`

## Requirements
- R1: After `rst_n` low, or after a one-cycle `soft_rst`, the following all read zero: the status word (select 0), the enable register (select 1), the runt count (select 2) and the queue ID (select 3). `irq` and `dma_halt` are also low.
- R2: Status bits are sticky. Writing select 0 clears exactly the bits written as one. A set event in the same cycle as a clear of that bit leaves the bit set.
- R3: Each `ev_runt_crc` cycle increments the runt count (select 2). The count saturates at all ones. A read of select 2 returns the current count and then clears it. An increment in the same cycle as that read leaves the count at 1.
- R4: Status bit 0 (runt overflow) is set in the cycle the runt count's most significant bit goes from 0 to 1. It is not set again while that bit stays high.
- R5: Each event sets its own status bit: management done bit 1, PHY change bit 2, timer zero bit 3, transmit status bit 5, other status bit 7.
- R6: `ev_rx_stat` sets status bit 6 only when enable bits 8, 9 and 10 (receive end-of-frame, end-of-buffer and header enables) are all one.
- R7: `ev_bus_abort` sets status bit 4 and raises `dma_halt` on the next edge. If bit 4 was clear, it also captures `abort_qid` into select 3. Later aborts keep the captured ID until bit 4 is cleared.
- R8: `dma_halt` stays high until `dma_restart` is pulsed while status bit 4 already reads clear. A restart while bit 4 is set is ignored.
- R9: `irq` is a register holding the OR of status bits 7:0 ANDed with enable bits 7:0. It rises one cycle after the status bit that causes it, and a status bit whose enable is zero never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of all state |
| ev_runt_crc | input | 1 | Runt frame with CRC error received |
| ev_mgmt_done | input | 1 | Management transaction completed |
| ev_phy_change | input | 1 | PHY change of status detected |
| ev_timer_zero | input | 1 | General timer reached zero |
| ev_bus_abort | input | 1 | Bus master cycle terminated abnormally |
| abort_qid | input | QID_W | DMA queue active at the abort |
| ev_tx_stat | input | 1 | Transmit status posted |
| ev_rx_stat | input | 1 | Receive status posted |
| ev_other | input | 1 | Other status pending |
| dma_restart | input | 1 | Restart request for halted DMA queues |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read-clear for select 2) |
| reg_sel | input | 2 | Register select: 0 status, 1 enable, 2 runt count, 3 queue ID |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register, combinational |
| irq | output | 1 | Registered interrupt request |
| dma_halt | output | 1 | Freeze for all DMA queues |

## Verification
Two functions can fall in the same cycle. The first is a hardware set of a status bit against a software write-one-to-clear of the same bit. The bench first sets the PHY bit, then drives the PHY event and a clearing write in one cycle, and expects the bit to still read one. The second is a runt increment against the read-clear of the counter. The bench holds the runt event during a read of select 2 and expects the old count from that read and 1 from the next. The abort path also joins restart with clearing: a restart issued while the abort bit is still set must leave the halt in place.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int ST_W = 8;
  localparam int B_RUNT   = 0;
  localparam int B_MGMT   = 1;
  localparam int B_PHY    = 2;
  localparam int B_TIMER  = 3;
  localparam int B_BUSERR = 4;
  localparam int B_TX     = 5;
  localparam int B_RX     = 6;
  localparam int B_OTHER  = 7;
  localparam int RX_GATE_N   = 3;
  localparam int RX_GATE_LSB = ST_W;
  localparam int EN_W        = ST_W + RX_GATE_N;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_RUNT   = 2'd2,
    SEL_QID    = 2'd3
  } reg_sel_e;

  function automatic logic irq_of(input logic [ST_W-1:0] st, input logic [ST_W-1:0] en);
    return |(st & en);
  endfunction

  function automatic logic gates_open(input logic [RX_GATE_N-1:0] g);
    return &g;
  endfunction
endpackage

// File: rtl/mac_irq_runt.sv
module mac_irq_runt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             inc,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    base  = rd_clr ? '0 : cnt_q;
    cnt_d = inc ? sat_step(base) : base;
    if (soft_rst) cnt_d = '0;
  end

  // overflow fires only on the 0 -> 1 change of the top bit
  assign ovf_evt = !soft_rst && !base[CNT_W-1] && cnt_d[CNT_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !rd_clr && !soft_rst) |=> cnt_q == CNT_MAX);
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !rd_clr && !soft_rst && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !inc && !soft_rst) |=> cnt_q == '0);
  a_r4_ovf_msb: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt_q[CNT_W-1] && !$past(cnt_q[CNT_W-1])) || $past(rd_clr));
endmodule

// File: rtl/mac_irq_abort.sv
module mac_irq_abort #(
  parameter int QID_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             abort,
  input  logic [QID_W-1:0] qid_in,
  input  logic             buserr_st,
  input  logic             restart,
  output logic             halt_q,
  output logic [QID_W-1:0] qid_q
);
  logic capture;
  logic release_ok;

  assign capture    = abort && !buserr_st;
  assign release_ok = restart && !buserr_st && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      qid_q  <= '0;
    end else if (soft_rst) begin
      halt_q <= 1'b0;
      qid_q  <= '0;
    end else begin
      if (capture)         qid_q  <= qid_in;
      if (abort)           halt_q <= 1'b1;
      else if (release_ok) halt_q <= 1'b0;
    end
  end

  a_r7_abort_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !soft_rst) |=> halt_q);
  a_r7_qid_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (buserr_st && !soft_rst) |=> $stable(qid_q));
  a_r8_halt_held: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !soft_rst && !(restart && !buserr_st)) |=> halt_q);
endmodule

// File: rtl/mac_irq_status.sv
module mac_irq_status
  import mac_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic [ST_W-1:0] set_vec,
  input  logic [ST_W-1:0] clr_vec,
  input  logic [ST_W-1:0] en,
  output logic [ST_W-1:0] st_q,
  output logic            irq_q
);
  logic [ST_W-1:0] st_d;

  // set has priority over a same-cycle write-one-to-clear
  assign st_d = (st_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else if (soft_rst) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= irq_of(st_q, en);
    end
  end

  a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && set_vec != '0) |=> (st_q & $past(set_vec)) == $past(set_vec));
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> (st_q & ~$past(st_q) & ~$past(set_vec)) == '0);
  a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && (st_q & en) == '0) |=> !irq_q);
  a_r9_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && (st_q & en) != '0) |=> irq_q);
endmodule

// File: rtl/mac_irq_agg.sv
module mac_irq_agg
  import mac_irq_pkg::*;
#(
  parameter int QID_W  = 3,
  parameter int RUNT_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              ev_runt_crc,
  input  logic              ev_mgmt_done,
  input  logic              ev_phy_change,
  input  logic              ev_timer_zero,
  input  logic              ev_bus_abort,
  input  logic [QID_W-1:0]  abort_qid,
  input  logic              ev_tx_stat,
  input  logic              ev_rx_stat,
  input  logic              ev_other,
  input  logic              dma_restart,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              dma_halt
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel);

  logic [EN_W-1:0]   en_q;
  logic [ST_W-1:0]   st_q;
  logic [ST_W-1:0]   set_vec;
  logic [ST_W-1:0]   clr_vec;
  logic [RUNT_W-1:0] runt_cnt;
  logic [QID_W-1:0]  qid_q;
  logic              runt_ovf;
  logic              runt_rd_clr;
  logic              rx_gate_ok;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[DATA_W-1:EN_W];

  // named internal events
  assign rx_gate_ok  = gates_open(en_q[RX_GATE_LSB +: RX_GATE_N]);
  assign runt_rd_clr = reg_rd && (sel == SEL_RUNT);
  assign clr_vec     = (reg_wr && sel == SEL_STATUS) ? reg_wdata[ST_W-1:0] : '0;

  always_comb begin
    set_vec           = '0;
    set_vec[B_RUNT]   = runt_ovf;
    set_vec[B_MGMT]   = ev_mgmt_done;
    set_vec[B_PHY]    = ev_phy_change;
    set_vec[B_TIMER]  = ev_timer_zero;
    set_vec[B_BUSERR] = ev_bus_abort;
    set_vec[B_TX]     = ev_tx_stat;
    set_vec[B_RX]     = ev_rx_stat && rx_gate_ok;
    set_vec[B_OTHER]  = ev_other;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             en_q <= '0;
    else if (soft_rst)                      en_q <= '0;
    else if (reg_wr && sel == SEL_ENABLE)   en_q <= reg_wdata[EN_W-1:0];
  end

  mac_irq_runt #(.CNT_W(RUNT_W)) u_runt (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .inc(ev_runt_crc), .rd_clr(runt_rd_clr),
    .cnt_q(runt_cnt), .ovf_evt(runt_ovf)
  );

  mac_irq_abort #(.QID_W(QID_W)) u_abort (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .abort(ev_bus_abort), .qid_in(abort_qid),
    .buserr_st(st_q[B_BUSERR]), .restart(dma_restart),
    .halt_q(dma_halt), .qid_q(qid_q)
  );

  mac_irq_status u_status (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .set_vec(set_vec), .clr_vec(clr_vec), .en(en_q[ST_W-1:0]),
    .st_q(st_q), .irq_q(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_STATUS: reg_rdata[ST_W-1:0]   = st_q;
      SEL_ENABLE: reg_rdata[EN_W-1:0]   = en_q;
      SEL_RUNT:   reg_rdata[RUNT_W-1:0] = runt_cnt;
      default:    reg_rdata[QID_W-1:0]  = qid_q;
    endcase
  end

  a_r6_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_q[B_RX] && !(ev_rx_stat && rx_gate_ok)) |=> !st_q[B_RX]);
  a_r1_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (st_q == '0 && en_q == '0 && runt_cnt == '0 && !dma_halt && !irq));
endmodule

// File: tb/test_mac_irq_agg.sv
`timescale 1ns/100ps
module test_mac_irq_agg;
  localparam int QID_W = 3;
  localparam int RUNT_W = 8;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic [7:0] ev = '0;   // index = status bit position
  logic [QID_W-1:0] abort_qid = '0;
  logic dma_restart = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic irq, dma_halt;

  int checks = 0;
  int failures = 0;
  logic [DATA_W-1:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  mac_irq_agg #(.QID_W(QID_W), .RUNT_W(RUNT_W), .DATA_W(DATA_W)) i_mac_irq_agg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .ev_runt_crc(ev[0]), .ev_mgmt_done(ev[1]), .ev_phy_change(ev[2]),
    .ev_timer_zero(ev[3]), .ev_bus_abort(ev[4]), .abort_qid(abort_qid),
    .ev_tx_stat(ev[5]), .ev_rx_stat(ev[6]), .ev_other(ev[7]),
    .dma_restart(dma_restart), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .dma_halt(dma_halt)
  );

  task automatic chk(input string tag, input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // scoreboard monitor: compares each read against the queued expectation
  always @(negedge clk) begin
    #1;
    if (reg_rd) begin
      if (exp_q.size() == 0) chk("R0 unexpected read", reg_rdata, '0);
      else chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(input logic [1:0] sel, input logic [DATA_W-1:0] exp, input string tag);
    reg_sel = sel; reg_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [DATA_W-1:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic fire(input logic [7:0] m, input int n);
    ev = m;
    repeat (n) @(negedge clk);
    ev = '0;
  endtask

  task automatic restart_pulse();
    dma_restart = 1'b1;
    @(negedge clk);
    dma_restart = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R0 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq after reset", irq, 0);
    chk("R1 halt after reset", dma_halt, 0);
    rd(0, 0, "R1 status after reset");
    rd(1, 0, "R1 enable after reset");
    rd(2, 0, "R1 runt after reset");
    rd(3, 0, "R1 qid after reset");

    // R5 / R9 single source and irq latency
    wr(1, 32'h0FF);
    rd(1, 32'h0FF, "R9 enable readback");
    fire(8'h02, 1);
    chk("R9 irq not yet raised", irq, 0);
    rd(0, 32'h02, "R5 mgmt bit");
    chk("R9 irq raised", irq, 1);
    wr(0, 32'h02);
    rd(0, 0, "R2 w1c clears mgmt");
    chk("R9 irq dropped", irq, 0);

    // R2 set wins against same-cycle clear, clear is selective
    fire(8'h06, 1);
    reg_sel = 0; reg_wdata = 32'h04; reg_wr = 1'b1; ev = 8'h04;
    @(negedge clk);
    reg_wr = 1'b0; ev = '0;
    rd(0, 32'h06, "R2 set wins over clear");
    wr(0, 32'h02);
    rd(0, 32'h04, "R2 selective clear");
    wr(0, 32'hFF);

    // R5 remaining sources together
    fire(8'hA8, 1);
    rd(0, 32'hA8, "R5 timer tx other bits");
    wr(0, 32'hFF);

    // R6 receive gating
    fire(8'h40, 1);
    rd(0, 0, "R6 rx blocked no gates");
    wr(1, 32'h3FF);
    fire(8'h40, 1);
    rd(0, 0, "R6 rx blocked two gates");
    wr(1, 32'h7FF);
    fire(8'h40, 1);
    rd(0, 32'h40, "R6 rx with all gates");
    wr(0, 32'hFF);

    // R9 masking
    wr(1, 32'h000);
    fire(8'h02, 1);
    repeat (2) @(negedge clk);
    chk("R9 masked source no irq", irq, 0);
    rd(0, 32'h02, "R9 masked status still set");
    wr(1, 32'h002);
    @(negedge clk);
    chk("R9 enabling raises irq", irq, 1);
    wr(0, 32'hFF);
    wr(1, 32'h0FF);

    // R3 counting, read-clear and coincident increment
    fire(8'h01, 3);
    rd(2, 3, "R3 count three");
    rd(2, 0, "R3 read cleared");
    fire(8'h01, 2);
    ev = 8'h01;
    rd(2, 2, "R3 read during increment");
    ev = '0;
    rd(2, 1, "R3 increment kept after read-clear");

    // R4 overflow on MSB, R3 saturation
    fire(8'h01, 127);
    rd(0, 0, "R4 no overflow below MSB");
    fire(8'h01, 1);
    rd(0, 32'h01, "R4 overflow at MSB");
    chk("R4 overflow irq", irq, 1);
    fire(8'h01, 200);
    wr(0, 32'h01);
    fire(8'h01, 1);
    rd(0, 0, "R4 no re-set while MSB high");
    rd(2, 255, "R3 saturate at all ones");
    rd(2, 0, "R3 cleared after saturate");

    // R7 abort capture and halt
    abort_qid = 3'd5;
    fire(8'h10, 1);
    chk("R7 halt on abort", dma_halt, 1);
    rd(3, 5, "R7 qid captured");
    rd(0, 32'h10, "R7 bus error bit");
    abort_qid = 3'd2;
    fire(8'h10, 1);
    rd(3, 5, "R7 first qid kept");
    // R8 restart ordering
    restart_pulse();
    chk("R8 restart ignored while set", dma_halt, 1);
    wr(0, 32'h10);
    chk("R8 halt held after clear", dma_halt, 1);
    restart_pulse();
    chk("R8 halt released", dma_halt, 0);
    rd(0, 0, "R8 status clear");
    abort_qid = 3'd3;
    fire(8'h10, 1);
    rd(3, 3, "R7 new qid after clear");

    // R1 soft reset
    fire(8'h03, 3);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R1 irq after soft reset", irq, 0);
    chk("R1 halt after soft reset", dma_halt, 0);
    rd(0, 0, "R1 status after soft reset");
    rd(1, 0, "R1 enable after soft reset");
    rd(2, 0, "R1 runt after soft reset");
    rd(3, 0, "R1 qid after soft reset");

    repeat (3) @(negedge clk);
    chk("R0 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule